// File: doc/BRIEF.md
# Update-Broadcast Coherence Controller with Competitive Drop

This block keeps one private, direct-mapped cache coherent with its peers on a shared bus. Shared copies are kept alike by broadcasting written data, not by invalidating. Each valid line carries one of four coherence states, formed from two choices: owned or unowned, and exclusive or sharable. An owned line is the one responsible for write-back. A local write to a sharable line puts the new word on the bus. Peer caches that hold the same line take the word in place, and memory is not written.

The snoop side watches the bus through a port separate from the CPU side. It answers reads from peers by raising a shared indication, and an owning cache supplies the data itself. A competitive mode limits the traffic that false sharing causes. A per-line counter tallies consecutive remote updates that the local CPU has not used. When the counter reaches the threshold `thr_i`, the line is dropped locally instead of being updated again.

The bus response is modelled as arriving in the same cycle as the request: fill data and the peers' shared indication come back combinationally. Memory itself is outside the block.

Top module: `upd_snoop_ctrl`

## Requirements
- R1: After reset every line is empty. A snoop to any address does not raise `snp_shared_o`, and the first CPU access to any address issues a bus read.
- R2: A CPU read miss issues a bus read (`bus_cmd_o`=0) for the full address and returns `bus_rdata_i` on `cpu_rdata_o` with `cpu_ready_o` high in the same cycle. The line is installed as unowned exclusive if `bus_shared_i` is low, and as unowned sharable if it is high.
- R3: A CPU write hit on an exclusive line (owned or unowned) completes with no bus transaction and leaves the line owned exclusive.
- R4: A CPU write hit on a sharable line issues an update (`bus_cmd_o`=1) carrying the address and the written word. The line then becomes owned sharable if `bus_shared_i` is high, and owned exclusive if it is low.
- R5: A snoop read (`snp_cmd_i`=0) that hits raises `snp_shared_o`. An owned line also raises `snp_supply_o`, drives its word on `snp_data_o` and becomes owned sharable. An unowned exclusive line becomes unowned sharable and supplies nothing.
- R6: A snoop update (`snp_cmd_i`=1) that hits replaces the stored word and leaves the line unowned sharable. Ownership passes to the writer, and no data is supplied.
- R7: A CPU miss whose victim is owned first issues a write-back (`bus_cmd_o`=2) of the victim's address and word, with `cpu_ready_o` low. The miss is then served in a later cycle. An unowned victim is replaced with no write-back.
- R8: With `thr_i` = n > 0, the n-th consecutive unused remote update to a line drops it. That update does not raise `snp_shared_o`, and the next CPU access to the line misses.
- R9: With `thr_i` = 0, snoop updates never drop a line.
- R10: Any local CPU read or write hit, and any fill, restarts the line's remote-update count from zero.
- R11: A CPU request is stalled (`cpu_ready_o` low) in any cycle in which a snoop addresses the same line index. Address bits [IDX_W-1:0] select the line, and the upper bits are the tag.
- R12: A CPU write miss first fills the line with a bus read, with `cpu_ready_o` low. The write then completes as a hit in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| thr_i | input | CNT_W | Competitive drop threshold; 0 disables dropping |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | ADDR_W | CPU word address |
| cpu_wdata_i | input | DATA_W | CPU write word |
| cpu_ready_o | output | 1 | CPU access completes this cycle |
| cpu_rdata_o | output | DATA_W | CPU read word, valid with ready on a read |
| bus_req_o | output | 1 | Local bus transaction this cycle |
| bus_cmd_o | output | 2 | 0 read, 1 update, 2 write-back, 3 idle |
| bus_addr_o | output | ADDR_W | Bus transaction address |
| bus_data_o | output | DATA_W | Word for update or write-back |
| bus_rdata_i | input | DATA_W | Fill word returned for a local read |
| bus_shared_i | input | 1 | A peer holds the line of the local transaction |
| snp_valid_i | input | 1 | Peer transaction seen on the bus |
| snp_cmd_i | input | 2 | Peer command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Peer transaction address |
| snp_data_i | input | DATA_W | Peer update word |
| snp_shared_o | output | 1 | This cache keeps a copy of the snooped line |
| snp_supply_o | output | 1 | This cache supplies the read data |
| snp_data_o | output | DATA_W | Supplied word |

## Verification
The bench sweeps every line index with a fill both with and without a peer sharer. It then writes the line and tells the state apart through bus behaviour: a wrongly installed state shows up as a spurious or missing update broadcast. A design that dropped ownership on a peer read would fail to supply data. One that never wrote back owned victims would skip the write-back cycle.

The threshold is swept from 1 to 5, including the case of a local read in the middle of a run of updates. An off-by-one counter would drop one update early or late. A counter that is not cleared by local use would drop the line too soon. A threshold of zero must keep the line through a long run of updates. Same-index snoop collisions must stall the CPU rather than lose an update.

// File: rtl/ucc_pkg.sv
`timescale 1ns/1ps
package ucc_pkg;
  // bit 1 = owned, bit 0 = sharable
  typedef enum logic [1:0] {
    ST_UE = 2'd0,
    ST_US = 2'd1,
    ST_OE = 2'd2,
    ST_OS = 2'd3
  } lstate_e;

  typedef enum logic [1:0] {
    BUS_READ   = 2'd0,
    BUS_UPDATE = 2'd1,
    BUS_WBACK  = 2'd2,
    BUS_IDLE   = 2'd3
  } bcmd_e;
endpackage

// File: rtl/ucc_line_array.sv
`timescale 1ns/1ps
module ucc_line_array
  import ucc_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic              cpu_vld_i,
  input  lstate_e           cpu_st_i,
  input  logic [TAG_W-1:0]  cpu_tag_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              snp_wr_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic              snp_vld_i,
  input  lstate_e           snp_st_i,
  input  logic [DATA_W-1:0] snp_data_i,
  input  logic [CNT_W-1:0]  snp_cnt_i,
  output logic              vld_o  [LINES],
  output lstate_e           st_o   [LINES],
  output logic [TAG_W-1:0]  tag_o  [LINES],
  output logic [DATA_W-1:0] data_o [LINES],
  output logic [CNT_W-1:0]  cnt_o  [LINES]
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        st_o[g]   <= ST_UE;
        tag_o[g]  <= '0;
        data_o[g] <= '0;
        cnt_o[g]  <= '0;
      end else if (snp_wr_i && snp_idx_i == MY_IDX) begin
        vld_o[g]  <= snp_vld_i;
        st_o[g]   <= snp_st_i;
        data_o[g] <= snp_data_i;
        cnt_o[g]  <= snp_cnt_i;
      end else if (cpu_wr_i && cpu_idx_i == MY_IDX) begin
        vld_o[g]  <= cpu_vld_i;
        st_o[g]   <= cpu_st_i;
        tag_o[g]  <= cpu_tag_i;
        data_o[g] <= cpu_data_i;
        cnt_o[g]  <= '0;
      end
    end
  end
endmodule

// File: rtl/ucc_cpu_side.sv
`timescale 1ns/1ps
module ucc_cpu_side
  import ucc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stall_i,
  input  logic              line_vld_i,
  input  lstate_e           line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              wr_o,
  output logic              n_vld_o,
  output lstate_e           n_st_o,
  output logic [TAG_W-1:0]  n_tag_o,
  output logic [DATA_W-1:0] n_data_o
);
  logic [TAG_W-1:0] tag;
  logic [IDX_W-1:0] idx;
  logic             hit;

  assign tag = addr_i[ADDR_W-1:IDX_W];
  assign idx = addr_i[IDX_W-1:0];
  assign hit = line_vld_i && (line_tag_i == tag);
  assign rdata_o = hit ? line_data_i : bus_rdata_i;

  always_comb begin
    ready_o    = 1'b0;
    bus_req_o  = 1'b0;
    bus_cmd_o  = BUS_IDLE;
    bus_addr_o = addr_i;
    bus_data_o = wdata_i;
    wr_o       = 1'b0;
    n_vld_o    = line_vld_i;
    n_st_o     = line_st_i;
    n_tag_o    = line_tag_i;
    n_data_o   = line_data_i;
    if (req_i && !stall_i) begin
      if (hit) begin
        ready_o = 1'b1;
        wr_o    = 1'b1;  // also clears the competitive count
        if (we_i) begin
          n_data_o = wdata_i;
          if (line_st_i[0]) begin
            bus_req_o = 1'b1;
            bus_cmd_o = BUS_UPDATE;
            n_st_o    = bus_shared_i ? ST_OS : ST_OE;
          end else begin
            n_st_o = ST_OE;
          end
        end
      end else if (line_vld_i && line_st_i[1]) begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = BUS_WBACK;
        bus_addr_o = {line_tag_i, idx};
        bus_data_o = line_data_i;
        wr_o       = 1'b1;
        n_vld_o    = 1'b0;
      end else begin
        bus_req_o = 1'b1;
        bus_cmd_o = BUS_READ;
        wr_o      = 1'b1;
        n_vld_o   = 1'b1;
        n_tag_o   = tag;
        n_data_o  = bus_rdata_i;
        n_st_o    = bus_shared_i ? ST_US : ST_UE;
        ready_o   = !we_i;
      end
    end
  end
endmodule

// File: rtl/ucc_snoop_side.sv
`timescale 1ns/1ps
module ucc_snoop_side
  import ucc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  thr_i,
  input  logic              line_vld_i,
  input  lstate_e           line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic [CNT_W-1:0]  line_cnt_i,
  output logic              hit_o,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] sdata_o,
  output logic              wr_o,
  output logic              n_vld_o,
  output lstate_e           n_st_o,
  output logic [DATA_W-1:0] n_data_o,
  output logic [CNT_W-1:0]  n_cnt_o
);
  logic [CNT_W-1:0] cnt_inc;

  assign hit_o   = valid_i && line_vld_i && (line_tag_i == addr_i[ADDR_W-1:IDX_W]);
  assign sdata_o = line_data_i;
  assign cnt_inc = (line_cnt_i == '1) ? line_cnt_i : line_cnt_i + 1'b1;

  always_comb begin
    shared_o = 1'b0;
    supply_o = 1'b0;
    wr_o     = 1'b0;
    n_vld_o  = line_vld_i;
    n_st_o   = line_st_i;
    n_data_o = line_data_i;
    n_cnt_o  = line_cnt_i;
    if (hit_o) begin
      if (cmd_i == BUS_READ) begin
        shared_o = 1'b1;
        supply_o = line_st_i[1];
        wr_o     = 1'b1;
        n_st_o   = line_st_i[1] ? ST_OS : ST_US;
      end else if (cmd_i == BUS_UPDATE) begin
        wr_o = 1'b1;
        if (thr_i != '0 && cnt_inc >= thr_i) begin
          n_vld_o = 1'b0;  // competitive drop: peer keeps sole copy
        end else begin
          shared_o = 1'b1;
          n_st_o   = ST_US;
          n_data_o = data_i;
          n_cnt_o  = cnt_inc;
        end
      end
    end
  end
endmodule

// File: rtl/upd_snoop_ctrl.sv
`timescale 1ns/1ps
module upd_snoop_ctrl
  import ucc_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  thr_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_data_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  logic              vld  [LINES];
  lstate_e           st   [LINES];
  logic [TAG_W-1:0]  tag  [LINES];
  logic [DATA_W-1:0] data [LINES];
  logic [CNT_W-1:0]  cnt  [LINES];

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic              collide;
  logic              c_wr, c_vld, s_wr, s_vld, snp_hit;
  lstate_e           c_st, s_st;
  logic [TAG_W-1:0]  c_tag;
  logic [DATA_W-1:0] c_data, s_data;
  logic [CNT_W-1:0]  s_cnt;

  assign c_idx   = cpu_addr_i[IDX_W-1:0];
  assign s_idx   = snp_addr_i[IDX_W-1:0];
  assign collide = snp_valid_i && (s_idx == c_idx);

  ucc_cpu_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cpu (
    .req_i(cpu_req_i), .we_i(cpu_we_i), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
    .stall_i(collide),
    .line_vld_i(vld[c_idx]), .line_st_i(st[c_idx]), .line_tag_i(tag[c_idx]),
    .line_data_i(data[c_idx]),
    .bus_rdata_i(bus_rdata_i), .bus_shared_i(bus_shared_i),
    .ready_o(cpu_ready_o), .rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o),
    .bus_data_o(bus_data_o),
    .wr_o(c_wr), .n_vld_o(c_vld), .n_st_o(c_st), .n_tag_o(c_tag), .n_data_o(c_data)
  );

  ucc_snoop_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_snp (
    .valid_i(snp_valid_i), .cmd_i(snp_cmd_i), .addr_i(snp_addr_i), .data_i(snp_data_i),
    .thr_i(thr_i),
    .line_vld_i(vld[s_idx]), .line_st_i(st[s_idx]), .line_tag_i(tag[s_idx]),
    .line_data_i(data[s_idx]), .line_cnt_i(cnt[s_idx]),
    .hit_o(snp_hit), .shared_o(snp_shared_o), .supply_o(snp_supply_o),
    .sdata_o(snp_data_o),
    .wr_o(s_wr), .n_vld_o(s_vld), .n_st_o(s_st), .n_data_o(s_data), .n_cnt_o(s_cnt)
  );

  ucc_line_array #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_lines (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_wr_i(c_wr), .cpu_idx_i(c_idx), .cpu_vld_i(c_vld), .cpu_st_i(c_st),
    .cpu_tag_i(c_tag), .cpu_data_i(c_data),
    .snp_wr_i(s_wr), .snp_idx_i(s_idx), .snp_vld_i(s_vld), .snp_st_i(s_st),
    .snp_data_i(s_data), .snp_cnt_i(s_cnt),
    .vld_o(vld), .st_o(st), .tag_o(tag), .data_o(data), .cnt_o(cnt)
  );
endmodule

// File: rtl/ucc_checker.sv
`timescale 1ns/1ps
module ucc_checker #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  thr_i,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ready_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic              snp_valid_i,
  input logic [1:0]        snp_cmd_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              snp_hit_i,
  input logic              snp_shared_o,
  input logic              snp_supply_o
);
  AST_SUPPLY_NEEDS_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_shared_o); // R5
  AST_UPDATE_NO_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 2'd1) |-> !snp_supply_o); // R6
  AST_SNOOP_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !snp_hit_i) |-> !snp_shared_o); // R1
  AST_UPDATE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == 2'd1) |-> (cpu_req_i && cpu_we_i && cpu_ready_o)); // R4
  AST_WBACK_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == 2'd2) |-> !cpu_ready_o); // R7
  AST_ZERO_THR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 2'd1 && snp_hit_i && thr_i == '0) |-> snp_shared_o); // R9
  AST_COLLIDE_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && snp_valid_i && cpu_addr_i[IDX_W-1:0] == snp_addr_i[IDX_W-1:0])
      |-> (!cpu_ready_o && !bus_req_o)); // R11
  AST_WRITE_MISS_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == 2'd0 && cpu_we_i) |-> !cpu_ready_o); // R12
endmodule

bind upd_snoop_ctrl ucc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .thr_i(thr_i),
  .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
  .cpu_ready_o(cpu_ready_o), .bus_req_o(bus_req_o), .bus_cmd_o(bus_cmd_o),
  .snp_valid_i(snp_valid_i), .snp_cmd_i(snp_cmd_i), .snp_addr_i(snp_addr_i),
  .snp_hit_i(snp_hit), .snp_shared_o(snp_shared_o), .snp_supply_o(snp_supply_o)
);

// File: tb/upd_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module upd_snoop_ctrl_tb;
  localparam int LINES = 4, ADDR_W = 6, DATA_W = 8, CNT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0]  thr = '0;
  logic              creq = 0, cwe = 0;
  logic [ADDR_W-1:0] caddr = '0;
  logic [DATA_W-1:0] cwd = '0, brd = '0, sd = '0;
  logic              bsh = 0, sv = 0;
  logic [1:0]        scmd = 2'd0;
  logic [ADDR_W-1:0] saddr = '0;

  logic              cready, breq, sshared, ssupply;
  logic [DATA_W-1:0] crdata, bdata, sdata;
  logic [1:0]        bcmd;
  logic [ADDR_W-1:0] baddr;

  // sampled observations
  logic              o_ready, o_breq, o_shared, o_supply;
  logic [DATA_W-1:0] o_rdata, o_bdata, o_sdata;
  logic [1:0]        o_bcmd;
  logic [ADDR_W-1:0] o_baddr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  upd_snoop_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .thr_i(thr),
    .cpu_req_i(creq), .cpu_we_i(cwe), .cpu_addr_i(caddr), .cpu_wdata_i(cwd),
    .cpu_ready_o(cready), .cpu_rdata_o(crdata),
    .bus_req_o(breq), .bus_cmd_o(bcmd), .bus_addr_o(baddr), .bus_data_o(bdata),
    .bus_rdata_i(brd), .bus_shared_i(bsh),
    .snp_valid_i(sv), .snp_cmd_i(scmd), .snp_addr_i(saddr), .snp_data_i(sd),
    .snp_shared_o(sshared), .snp_supply_o(ssupply), .snp_data_o(sdata)
  );

  function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
    return {4'(t), 2'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] rd,
                      input logic sh, input logic v, input logic [1:0] c,
                      input logic [ADDR_W-1:0] sa, input logic [DATA_W-1:0] sdi);
    @(negedge clk);
    creq = r; cwe = w; caddr = a; cwd = wd; brd = rd; bsh = sh;
    sv = v; scmd = c; saddr = sa; sd = sdi;
    #1;
    o_ready = cready; o_rdata = crdata; o_breq = breq; o_bcmd = bcmd;
    o_baddr = baddr; o_bdata = bdata; o_shared = sshared; o_supply = ssupply;
    o_sdata = sdata;
    @(posedge clk);
  endtask

  task automatic cpu(input logic w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                     input logic [DATA_W-1:0] rd, input logic sh);
    step(1, w, a, wd, rd, sh, 0, 2'd0, '0, '0);
  endtask

  task automatic snp(input logic [1:0] c, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    step(0, 0, '0, '0, '0, 0, 1, c, a, d);
  endtask

  task automatic idle();
    step(0, 0, '0, '0, '0, 0, 0, 2'd0, '0, '0);
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic sh);
    for (int k = 0; k < 4; k++) begin
      cpu(0, a, '0, d, sh);
      if (o_ready) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    for (int i = 0; i < LINES; i++) begin
      snp(2'd0, mk(0, i), '0);
      chk(!o_shared, "R1 snoop after reset", o_shared, 0);
    end
    cpu(0, mk(0, 0), '0, 8'h11, 0);
    chk(o_breq && o_bcmd == 2'd0, "R1 first access reads bus", {o_breq, o_bcmd}, 3'b100);

    // Sweep: every index, fill without and with a sharer
    for (int i = 0; i < LINES; i++) begin
      for (int s = 0; s < 2; s++) begin
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d, w1, w2;
        a  = mk(s + 1, i);
        d  = 8'(8'h20 + i * 4 + s);
        w1 = 8'(8'h60 + i * 4 + s);
        w2 = 8'(8'hA0 + i * 4 + s);
        if (s == 1) begin
          // R7: owned sharable victim from previous pass
          cpu(0, a, '0, d, 1'b1);
          chk(o_breq && o_bcmd == 2'd2 && !o_ready, "R7 owned victim writes back",
              {o_breq, o_bcmd, o_ready}, 4'b1100);
          chk(o_baddr == mk(1, i) && o_bdata == 8'(8'hA0 + i * 4),
              "R7 write-back address/data", {o_baddr, o_bdata}, {mk(1, i), 8'(8'hA0 + i * 4)});
        end
        cpu(0, a, '0, d, 1'(s));
        chk(o_breq && o_bcmd == 2'd0 && o_baddr == a, "R2 read miss bus read",
            {o_breq, o_bcmd, o_baddr}, {1'b1, 2'd0, a});
        chk(o_ready && o_rdata == d, "R2 read miss data", o_rdata, d);
        // R12: write miss would fill first; here hit after fill
        cpu(1, a, w1, '0, 1'b0);
        if (s == 0)
          chk(!o_breq && o_ready, "R3 write to unowned exclusive silent", o_breq, 0);
        else
          chk(o_breq && o_bcmd == 2'd1 && o_bdata == w1 && o_baddr == a,
              "R4 write to sharable broadcasts", {o_breq, o_bcmd, o_bdata}, {1'b1, 2'd1, w1});
        snp(2'd0, a, '0);
        chk(o_shared && o_supply && o_sdata == w1, "R5 owner supplies",
            {o_shared, o_supply, o_sdata}, {2'b11, w1});
        cpu(1, a, w2, '0, 1'b1);
        chk(o_breq && o_bcmd == 2'd1 && o_bdata == w2, "R4 owned sharable broadcasts",
            {o_breq, o_bcmd}, 3'b101);
        snp(2'd0, a, '0);
        chk(o_supply && o_sdata == w2, "R5 owned sharable keeps ownership",
            {o_supply, o_sdata}, {1'b1, w2});
      end
    end

    // R3: owned exclusive stays silent on repeated write
    fill(mk(9, 1), 8'h31, 1'b0);
    cpu(1, mk(9, 1), 8'h32, '0, 1'b0);
    cpu(1, mk(9, 1), 8'h33, '0, 1'b0);
    chk(!o_breq && o_ready, "R3 owned exclusive write silent", o_breq, 0);
    // R4: broadcast with no sharer -> owned exclusive -> next write silent
    fill(mk(10, 1), 8'h40, 1'b1);
    cpu(1, mk(10, 1), 8'h41, '0, 1'b0);
    chk(o_breq && o_bcmd == 2'd1, "R4 broadcast on sharable", o_bcmd, 1);
    cpu(1, mk(10, 1), 8'h42, '0, 1'b0);
    chk(!o_breq, "R4 no sharer gives owned exclusive", o_breq, 0);

    // R5: unowned exclusive becomes sharable on snoop read, supplies nothing
    fill(mk(11, 2), 8'h50, 1'b0);
    snp(2'd0, mk(11, 2), '0);
    chk(o_shared && !o_supply, "R5 unowned does not supply", {o_shared, o_supply}, 2'b10);
    cpu(1, mk(11, 2), 8'h51, '0, 1'b1);
    chk(o_breq && o_bcmd == 2'd1, "R5 unowned exclusive became sharable", o_bcmd, 1);

    // R7: unowned victim, no write-back
    fill(mk(12, 0), 8'h70, 1'b1);
    cpu(0, mk(13, 0), '0, 8'h71, 1'b1);
    chk(o_breq && o_bcmd == 2'd0 && o_ready, "R7 unowned victim no write-back",
        {o_breq, o_bcmd, o_ready}, 4'b1001);

    // R12: write miss fills first then completes
    cpu(1, mk(14, 0), 8'h7E, 8'h7D, 1'b0);
    chk(o_breq && o_bcmd == 2'd0 && !o_ready, "R12 write miss fills first",
        {o_breq, o_bcmd, o_ready}, 4'b1000);
    cpu(1, mk(14, 0), 8'h7E, '0, 1'b0);
    chk(o_ready && !o_breq, "R12 write completes as hit", {o_ready, o_breq}, 2'b10);
    cpu(0, mk(14, 0), '0, '0, 1'b0);
    chk(o_rdata == 8'h7E && !o_breq, "R12 written word kept", o_rdata, 8'h7E);

    // R6: snoop update replaces word and removes ownership (line 2 is owned sharable)
    thr = '0;
    snp(2'd1, mk(11, 2), 8'h5A);
    chk(o_shared && !o_supply, "R6 update keeps copy", {o_shared, o_supply}, 2'b10);
    cpu(0, mk(11, 2), '0, 8'hEE, 1'b0);
    chk(!o_breq && o_rdata == 8'h5A, "R6 updated word read", o_rdata, 8'h5A);
    snp(2'd0, mk(11, 2), '0);
    chk(!o_supply && o_shared, "R6 ownership lost", o_supply, 0);

    // R9: zero threshold never drops
    for (int k = 0; k < 10; k++) begin
      snp(2'd1, mk(11, 2), 8'(k));
      chk(o_shared, "R9 zero threshold keeps line", o_shared, 1);
    end
    cpu(0, mk(11, 2), '0, 8'hEE, 1'b0);
    chk(!o_breq && o_rdata == 8'd9, "R9 line still valid", {o_breq, o_rdata}, {1'b0, 8'd9});

    // R8/R10: threshold sweep on line 3
    for (int t = 1; t <= 5; t++) begin
      thr = 3'(t);
      fill(mk(5, 3), 8'h90, 1'b1);
      for (int k = 0; k < t - 1; k++) begin
        snp(2'd1, mk(5, 3), 8'(k));
        chk(o_shared, "R8 below threshold keeps", o_shared, 1);
      end
      cpu(0, mk(5, 3), '0, '0, 1'b0);
      chk(!o_breq, "R10 local read hits", o_breq, 0);
      for (int k = 0; k < t - 1; k++) begin
        snp(2'd1, mk(5, 3), 8'(k));
        chk(o_shared, "R10 count restarted", o_shared, 1);
      end
      snp(2'd1, mk(5, 3), 8'hFF);
      chk(!o_shared, "R8 threshold update drops", o_shared, 0);
      cpu(0, mk(5, 3), '0, 8'h91, 1'b0);
      chk(o_breq && o_bcmd == 2'd0 && o_rdata == 8'h91, "R8 dropped line misses",
          {o_breq, o_bcmd}, 3'b100);
    end
    thr = '0;

    // R11: same-index snoop stalls CPU
    fill(mk(2, 1), 8'hC1, 1'b0);
    step(1, 0, mk(2, 1), '0, '0, 0, 1, 2'd0, mk(7, 1), '0);
    chk(!o_ready && !o_breq, "R11 same index stalls", {o_ready, o_breq}, 2'b00);
    step(1, 0, mk(2, 1), '0, '0, 0, 1, 2'd0, mk(7, 2), '0);
    chk(o_ready && o_rdata == 8'hC1, "R11 other index proceeds", o_rdata, 8'hC1);

    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule